// File: doc/BRIEF.md
# Radix-4 FFT Butterfly Stage

This block is one pipelined stage of a radix-4 fixed-point FFT. Every clock cycle it accepts four complex samples, multiplies each by a twiddle constant, and then combines them through two rows of exact complex additions into the four outputs of a 4-point DFT. The twiddle constants are fixed at elaboration. A parameter selects one of two twiddle rows. The trivial row multiplies only by +1, +j, -1 or -j, so it is exact and keeps the input fraction width. The general row multiplies by constant roots of unity and rounds each complex product once, to a chosen fraction width.

No addition rounds and none saturates. Each addition row widens the integer part by one bit, so the output integer width is the input integer width plus two. A multiplication by a root of unity leaves the integer width unchanged. Stimulus is assumed never to use the most negative code, and is assumed not to push a rotated product past the input range. The datapath registers advance on every clock edge. A single valid bit travels beside the data with the same fixed latency of four cycles: two register levels in the twiddle row and one in each addition row.

Several such stages can be chained. The integer width grows by two bits per stage, and the fraction width becomes fixed once a general twiddle row has introduced it.

Top module: `fft4_stage`

## Requirements
- R1: While reset is asserted, and after reset until the first valid input has had time to arrive, `out_valid` is 0; every output data bit is 0 while reset is held.
- R2: `out_valid` equals `in_valid` delayed by exactly four clock cycles.
- R3: Output data in the cycle that `out_valid` is 1 belongs to the input vector presented four cycles earlier, with no mixing of neighbouring vectors.
- R4: With `GENERAL`=0, lane k is multiplied by j^c, where c is the 2-bit field `ROT_CODES[2k+1:2k]` (0: +1, 1: +j, 2: -1, 3: -j). The result is exact, and the fraction width stays `IN_FRAC`.
- R5: With `GENERAL`=1, lane k is multiplied by the constant (`TW_RE[k]` + j·`TW_IM[k]`)·2^-CF, where each constant is a signed `CW`-bit field at bits [k·CW+CW-1 : k·CW]. The exact real and imaginary sums of products are each rounded once, half away from zero, to `OUT_FRAC` fraction bits. The integer width is unchanged.
- R6: The first addition row forms, from twiddled values y0..y3, a0=y0+y2, a1=y0-y2, a2=y1+y3 and a3=y1-y3, exactly.
- R7: The second addition row forms X0=a0+a2, X2=a0-a2, X1=a1-j·a3 and X3=a1+j·a3, exactly. The overall result is the forward 4-point DFT X_k = Σ y_n·(-j)^(nk).
- R8: Each output lane is a signed (IN_INT+2+MF)-bit value, where MF is `OUT_FRAC` when `GENERAL`=1 and `IN_FRAC` otherwise. Lane k sits at bits [k·OW+OW-1 : k·OW]; input lane k sits at bits [k·IW+IW-1 : k·IW].
- R9: The stage accepts a new vector every cycle. Back-to-back vectors each produce their own correct result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the current input vector as meaningful |
| in_re | input | 4*(IN_INT+IN_FRAC) | Real parts of the four input samples, lane 0 in the low bits |
| in_im | input | 4*(IN_INT+IN_FRAC) | Imaginary parts of the four input samples |
| out_valid | output | 1 | `in_valid` delayed by four cycles |
| out_re | output | 4*(IN_INT+2+MF) | Real parts of the four DFT outputs |
| out_im | output | 4*(IN_INT+2+MF) | Imaginary parts of the four DFT outputs |

## Verification
Two things can happen in the same cycle here. A vector can enter while an earlier one leaves, with idle beats interleaved in the pipe. Separately, a vector's twiddle rounding and its widest addition growth both fall on the same set of values. The first is provoked by an unbroken burst of valid vectors followed by random valid gaps, and it is judged by checking `out_valid` on every cycle and each result against its own vector. The second is provoked by full-scale directed vectors and random signed values through two instances, one trivial and one with general twiddles. Each output is compared bit for bit with a model that computes the DFT as a sum over rotations, rather than as butterflies.

// File: rtl/fft4_pkg.sv
package fft4_pkg;

  localparam int LANES     = 4;
  localparam int LAT_MUL   = 2;
  localparam int LAT_ADD   = 1;
  localparam int STAGE_LAT = LAT_MUL + 2 * LAT_ADD;

  // multiplier of the trivial twiddle row: j^code
  typedef enum logic [1:0] {
    ROT_POS_ONE = 2'd0,
    ROT_POS_J   = 2'd1,
    ROT_NEG_ONE = 2'd2,
    ROT_NEG_J   = 2'd3
  } rot_e;

  // drop s fraction bits, ties rounded away from zero
  function automatic logic signed [63:0] round_half_away(
      input logic signed [63:0] v, input int s);
    logic signed [63:0] bias;
    bias = (64'sd1 <<< (s - 1)) - (v[63] ? 64'sd1 : 64'sd0);
    return (v + bias) >>> s;
  endfunction

endpackage

// File: rtl/fft4_twiddle_lane.sv
module fft4_twiddle_lane #(
  parameter int         IN_INT   = 1,
  parameter int         IN_FRAC  = 4,
  parameter int         OUT_FRAC = 9,
  parameter bit         GENERAL  = 1'b0,
  parameter logic [1:0] ROT      = 2'd0,
  parameter int         CW       = 16,
  parameter int         CF       = 14,
  parameter int         C_RE     = 16384,
  parameter int         C_IM     = 0,
  localparam int IW = IN_INT + IN_FRAC,
  localparam int MF = GENERAL ? OUT_FRAC : IN_FRAC,
  localparam int OW = IN_INT + MF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [IW-1:0] in_re,
  input  logic signed [IW-1:0] in_im,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im
);

  generate
    if (GENERAL) begin : g_general
      localparam int PW = IW + CW;
      localparam int SW = PW + 1;
      localparam int SH = IN_FRAC + CF - MF;
      localparam logic signed [CW-1:0] CR = CW'(C_RE);
      localparam logic signed [CW-1:0] CI = CW'(C_IM);

      logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
      logic signed [SW-1:0] sum_re, sum_im;

      // level 1: four exact partial products
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          p_rr <= '0;
          p_ii <= '0;
          p_ri <= '0;
          p_ir <= '0;
        end else begin
          p_rr <= PW'(in_re) * PW'(CR);
          p_ii <= PW'(in_im) * PW'(CI);
          p_ri <= PW'(in_re) * PW'(CI);
          p_ir <= PW'(in_im) * PW'(CR);
        end
      end

      always_comb begin
        sum_re = SW'(p_rr) - SW'(p_ii);
        sum_im = SW'(p_ri) + SW'(p_ir);
      end

      // level 2: one rounding of each exact complex component
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_re <= '0;
          out_im <= '0;
        end else begin
          out_re <= OW'(fft4_pkg::round_half_away(64'(sum_re), SH));
          out_im <= OW'(fft4_pkg::round_half_away(64'(sum_im), SH));
        end
      end
    end else begin : g_trivial
      logic signed [IW-1:0] r1_re, r1_im;
      logic [1:0]           warm;
      logic signed [63:0]   mag_in, mag_out;

      // level 1: exact rotation by a power of j
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r1_re <= '0;
          r1_im <= '0;
        end else begin
          unique case (fft4_pkg::rot_e'(ROT))
            fft4_pkg::ROT_POS_ONE: begin r1_re <= in_re;  r1_im <= in_im;  end
            fft4_pkg::ROT_POS_J:   begin r1_re <= -in_im; r1_im <= in_re;  end
            fft4_pkg::ROT_NEG_ONE: begin r1_re <= -in_re; r1_im <= -in_im; end
            default:               begin r1_re <= in_im;  r1_im <= -in_re; end
          endcase
        end
      end

      // level 2: balancing register so both row variants share one latency
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_re <= '0;
          out_im <= '0;
          warm   <= '0;
        end else begin
          out_re <= r1_re;
          out_im <= r1_im;
          if (warm != 2'd2) warm <= warm + 2'd1;
        end
      end

      always_comb begin
        mag_in  = 64'(in_re) * 64'(in_re) + 64'(in_im) * 64'(in_im);
        mag_out = 64'(out_re) * 64'(out_re) + 64'(out_im) * 64'(out_im);
      end

      // R4: a rotation by a power of j keeps the squared magnitude exactly
      assert_rot_keeps_mag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (mag_out == $past(mag_in, 2)));
    end
  endgenerate

endmodule

// File: rtl/fft4_add_row.sv
module fft4_add_row #(
  parameter int W      = 5,
  parameter bit SECOND = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic signed [W-1:0] i_re [4],
  input  logic signed [W-1:0] i_im [4],
  output logic signed [W:0]   o_re [4],
  output logic signed [W:0]   o_im [4]
);

  localparam int OW = W + 1;

  logic warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;
  end

  generate
    if (!SECOND) begin : g_row1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < 4; k++) begin
            o_re[k] <= '0;
            o_im[k] <= '0;
          end
        end else begin
          o_re[0] <= OW'(i_re[0]) + OW'(i_re[2]);
          o_im[0] <= OW'(i_im[0]) + OW'(i_im[2]);
          o_re[1] <= OW'(i_re[0]) - OW'(i_re[2]);
          o_im[1] <= OW'(i_im[0]) - OW'(i_im[2]);
          o_re[2] <= OW'(i_re[1]) + OW'(i_re[3]);
          o_im[2] <= OW'(i_im[1]) + OW'(i_im[3]);
          o_re[3] <= OW'(i_re[1]) - OW'(i_re[3]);
          o_im[3] <= OW'(i_im[1]) - OW'(i_im[3]);
        end
      end

      logic signed [W+1:0] pair_re, pair_im, twice_re, twice_im;
      always_comb begin
        pair_re  = (W+2)'(o_re[0]) + (W+2)'(o_re[1]);
        pair_im  = (W+2)'(o_im[0]) + (W+2)'(o_im[1]);
        twice_re = (W+2)'(i_re[0]) <<< 1;
        twice_im = (W+2)'(i_im[0]) <<< 1;
      end

      // R6: sum and difference of one pair recover twice the common term
      assert_row1_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (pair_re == $past(twice_re) && pair_im == $past(twice_im)));
    end else begin : g_row2
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < 4; k++) begin
            o_re[k] <= '0;
            o_im[k] <= '0;
          end
        end else begin
          o_re[0] <= OW'(i_re[0]) + OW'(i_re[2]);
          o_im[0] <= OW'(i_im[0]) + OW'(i_im[2]);
          o_re[2] <= OW'(i_re[0]) - OW'(i_re[2]);
          o_im[2] <= OW'(i_im[0]) - OW'(i_im[2]);
          // X1 = a1 - j*a3, X3 = a1 + j*a3
          o_re[1] <= OW'(i_re[1]) + OW'(i_im[3]);
          o_im[1] <= OW'(i_im[1]) - OW'(i_re[3]);
          o_re[3] <= OW'(i_re[1]) - OW'(i_im[3]);
          o_im[3] <= OW'(i_im[1]) + OW'(i_re[3]);
        end
      end

      logic signed [W+1:0] ev_re, ev_im, od_re, od_im;
      logic signed [W+1:0] t0_re, t0_im, t1_re, t1_im;
      always_comb begin
        ev_re = (W+2)'(o_re[0]) + (W+2)'(o_re[2]);
        ev_im = (W+2)'(o_im[0]) + (W+2)'(o_im[2]);
        od_re = (W+2)'(o_re[1]) + (W+2)'(o_re[3]);
        od_im = (W+2)'(o_im[1]) + (W+2)'(o_im[3]);
        t0_re = (W+2)'(i_re[0]) <<< 1;
        t0_im = (W+2)'(i_im[0]) <<< 1;
        t1_re = (W+2)'(i_re[1]) <<< 1;
        t1_im = (W+2)'(i_im[1]) <<< 1;
      end

      // R7: opposite outputs add back to twice the feeding term
      assert_row2_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (ev_re == $past(t0_re) && ev_im == $past(t0_im) &&
                  od_re == $past(t1_re) && od_im == $past(t1_im)));
    end
  endgenerate

endmodule

// File: rtl/fft4_stage.sv
module fft4_stage #(
  parameter int            IN_INT    = 1,
  parameter int            IN_FRAC   = 4,
  parameter int            OUT_FRAC  = 9,
  parameter bit            GENERAL   = 1'b0,
  parameter logic [7:0]    ROT_CODES = 8'b11_10_01_00,
  parameter int            CW        = 16,
  parameter int            CF        = 14,
  parameter logic [4*CW-1:0] TW_RE   = {16'sd6270, 16'sd11585, 16'sd15137, 16'sd16384},
  parameter logic [4*CW-1:0] TW_IM   = {-16'sd15137, -16'sd11585, -16'sd6270, 16'sd0},
  localparam int IW = IN_INT + IN_FRAC,
  localparam int MF = GENERAL ? OUT_FRAC : IN_FRAC,
  localparam int MW = IN_INT + MF,
  localparam int OW = MW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [4*IW-1:0] in_re,
  input  logic [4*IW-1:0] in_im,
  output logic            out_valid,
  output logic [4*OW-1:0] out_re,
  output logic [4*OW-1:0] out_im
);

  localparam int LAT = fft4_pkg::STAGE_LAT;

  logic signed [IW-1:0]   x_re [4];
  logic signed [IW-1:0]   x_im [4];
  logic signed [MW-1:0]   y_re [4];
  logic signed [MW-1:0]   y_im [4];
  logic signed [MW:0]     a_re [4];
  logic signed [MW:0]     a_im [4];
  logic signed [MW+1:0]   f_re [4];
  logic signed [MW+1:0]   f_im [4];

  genvar k;
  generate
    for (k = 0; k < fft4_pkg::LANES; k++) begin : g_lane
      localparam logic signed [CW-1:0] CRE = TW_RE[k*CW +: CW];
      localparam logic signed [CW-1:0] CIM = TW_IM[k*CW +: CW];

      assign x_re[k] = in_re[k*IW +: IW];
      assign x_im[k] = in_im[k*IW +: IW];

      fft4_twiddle_lane #(
        .IN_INT  (IN_INT),
        .IN_FRAC (IN_FRAC),
        .OUT_FRAC(OUT_FRAC),
        .GENERAL (GENERAL),
        .ROT     (ROT_CODES[2*k +: 2]),
        .CW      (CW),
        .CF      (CF),
        .C_RE    (int'(CRE)),
        .C_IM    (int'(CIM))
      ) u_tw (
        .clk   (clk),
        .rst_n (rst_n),
        .in_re (x_re[k]),
        .in_im (x_im[k]),
        .out_re(y_re[k]),
        .out_im(y_im[k])
      );

      assign out_re[k*OW +: OW] = f_re[k];
      assign out_im[k*OW +: OW] = f_im[k];
    end
  endgenerate

  fft4_add_row #(.W(MW), .SECOND(1'b0)) u_row1 (
    .clk(clk), .rst_n(rst_n),
    .i_re(y_re), .i_im(y_im), .o_re(a_re), .o_im(a_im)
  );

  fft4_add_row #(.W(MW + 1), .SECOND(1'b1)) u_row2 (
    .clk(clk), .rst_n(rst_n),
    .i_re(a_re), .i_im(a_im), .o_re(f_re), .o_im(f_im)
  );

  // valid tag walks beside the data
  logic [LAT-1:0] vpipe;
  logic [2:0]     since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpipe     <= '0;
      since_rst <= '0;
    end else begin
      vpipe <= {vpipe[LAT-2:0], in_valid};
      if (since_rst != 3'(LAT)) since_rst <= since_rst + 3'd1;
    end
  end

  assign out_valid = vpipe[LAT-1];

  // R2: fixed four-cycle delay of the valid tag
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'(LAT)) |-> (out_valid == $past(in_valid, 4)));

  // R1: nothing can emerge before a valid input has crossed the pipe
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 3'(LAT)) |-> !out_valid);

  // energy of the two addition rows: sum |X|^2 = 4 * sum |y|^2
  logic signed [63:0] e_tw, e_out;
  always_comb begin
    e_tw  = '0;
    e_out = '0;
    for (int n = 0; n < 4; n++) begin
      e_tw  = e_tw  + 64'(y_re[n]) * 64'(y_re[n]) + 64'(y_im[n]) * 64'(y_im[n]);
      e_out = e_out + 64'(f_re[n]) * 64'(f_re[n]) + 64'(f_im[n]) * 64'(f_im[n]);
    end
  end

  // R7: two exact addition rows scale the energy by exactly four
  assert_parseval_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd2) |-> (e_out == ($past(e_tw, 2) <<< 2)));

endmodule

// File: tb/fft4_stage_tb.sv
module fft4_stage_tb;

  localparam int NCYC   = 600;
  localparam int WDOG   = 5000;
  // instance A: trivial row, 1.4 input
  localparam int A_IW = 5;
  localparam int A_OW = 7;
  localparam int A_LIM = 15;
  // instance B: general row, 3.4 input, 9 fraction bits out
  localparam int B_IW = 7;
  localparam int B_OW = 14;
  localparam int B_LIM = 44;
  localparam int B_SH = 4 + 14 - 9;

  localparam logic [63:0] B_TW_RE = {16'sd6270, 16'sd11585, 16'sd15137, 16'sd16384};
  localparam logic [63:0] B_TW_IM = {-16'sd15137, -16'sd11585, -16'sd6270, 16'sd0};
  localparam logic [7:0]  A_ROT   = 8'b11_10_01_00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vin = 1'b0;
  logic [4*A_IW-1:0] a_in_re = '0, a_in_im = '0;
  logic [4*B_IW-1:0] b_in_re = '0, b_in_im = '0;
  logic a_vld, b_vld;
  logic [4*A_OW-1:0] a_out_re, a_out_im;
  logic [4*B_OW-1:0] b_out_re, b_out_im;

  always #5 clk = ~clk;

  fft4_stage #(.IN_INT(1), .IN_FRAC(4), .GENERAL(1'b0), .ROT_CODES(A_ROT)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_re(a_in_re), .in_im(a_in_im),
    .out_valid(a_vld), .out_re(a_out_re), .out_im(a_out_im)
  );

  fft4_stage #(.IN_INT(3), .IN_FRAC(4), .OUT_FRAC(9), .GENERAL(1'b1),
               .CW(16), .CF(14), .TW_RE(B_TW_RE), .TW_IM(B_TW_IM)) u_dut_tw (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_re(b_in_re), .in_im(b_in_im),
    .out_valid(b_vld), .out_re(b_out_re), .out_im(b_out_im)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic   hv [8];
  string  hs [8];
  longint ea_re [8][4], ea_im [8][4], eb_re [8][4], eb_im [8][4];

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // multiply (r,i) by +j once
  function automatic void turn_pj(inout longint r, inout longint i);
    longint t = r;
    r = -i;
    i = t;
  endfunction

  // multiply (r,i) by -j once
  function automatic void turn_mj(inout longint r, inout longint i);
    longint t = r;
    r = i;
    i = -t;
  endfunction

  // magnitude rounded half away from zero, sign restored afterwards
  function automatic longint rnd_away(input longint v, input int s);
    longint m = (v < 0) ? -v : v;
    longint unit = longint'(1) << s;
    m = (m + unit / 2) / unit;
    return (v < 0) ? -m : m;
  endfunction

  // 4-point DFT as a sum of rotated terms
  task automatic dft4(input longint yr [4], input longint yi [4],
                      output longint xr [4], output longint xi [4]);
    for (int k = 0; k < 4; k++) begin
      xr[k] = 0;
      xi[k] = 0;
      for (int n = 0; n < 4; n++) begin
        longint r = yr[n];
        longint i = yi[n];
        for (int m = 0; m < (n * k) % 4; m++) turn_mj(r, i);
        xr[k] += r;
        xi[k] += i;
      end
    end
  endtask

  function automatic int dir_val(input int t, input int k, input int part, input int lim);
    case (t)
      0: return (k == 0 && part == 0) ? lim : 0;
      1: return lim;
      2: return -lim;
      3: return (k % 2) ? -lim : lim;
      4: return 0;
      5: return part ? lim : -lim;
      6: return (k == 3) ? lim : 0;
      7: return ((k + part) % 2) ? lim : -lim;
      default: return (k == t - 8) ? -lim : lim;
    endcase
  endfunction

  function automatic int rnd_val(input int lim);
    return int'($urandom % (2 * lim + 1)) - lim;
  endfunction

  task automatic drive(input int t, input logic v, input string tag);
    int     axr [4], axi [4], bxr [4], bxi [4];
    longint yr [4], yi [4], xr [4], xi [4];
    int     slot = t % 8;
    for (int k = 0; k < 4; k++) begin
      if (t < 12) begin
        axr[k] = dir_val(t, k, 0, A_LIM); axi[k] = dir_val(t, k, 1, A_LIM);
        bxr[k] = dir_val(t, k, 0, B_LIM); bxi[k] = dir_val(t, k, 1, B_LIM);
      end else begin
        axr[k] = rnd_val(A_LIM); axi[k] = rnd_val(A_LIM);
        bxr[k] = rnd_val(B_LIM); bxi[k] = rnd_val(B_LIM);
      end
      a_in_re[k*A_IW +: A_IW] = A_IW'(axr[k]);
      a_in_im[k*A_IW +: A_IW] = A_IW'(axi[k]);
      b_in_re[k*B_IW +: B_IW] = B_IW'(bxr[k]);
      b_in_im[k*B_IW +: B_IW] = B_IW'(bxi[k]);
    end
    vin = v;
    // model A: rotate lane k by j^code
    for (int k = 0; k < 4; k++) begin
      yr[k] = axr[k];
      yi[k] = axi[k];
      for (int m = 0; m < int'(A_ROT[2*k +: 2]); m++) turn_pj(yr[k], yi[k]);
    end
    dft4(yr, yi, xr, xi);
    for (int k = 0; k < 4; k++) begin ea_re[slot][k] = xr[k]; ea_im[slot][k] = xi[k]; end
    // model B: exact complex product, one rounding per component
    for (int k = 0; k < 4; k++) begin
      longint cr = longint'($signed(B_TW_RE[k*16 +: 16]));
      longint ci = longint'($signed(B_TW_IM[k*16 +: 16]));
      yr[k] = rnd_away(bxr[k] * cr - bxi[k] * ci, B_SH);
      yi[k] = rnd_away(bxr[k] * ci + bxi[k] * cr, B_SH);
    end
    dft4(yr, yi, xr, xi);
    for (int k = 0; k < 4; k++) begin eb_re[slot][k] = xr[k]; eb_im[slot][k] = xi[k]; end
    hv[slot] = v;
    hs[slot] = tag;
  endtask

  task automatic check_out(input int t);
    int slot = (t + 4) % 8;
    chk("R2 out_valid A", longint'(a_vld), longint'(hv[slot]));
    chk("R2 out_valid B", longint'(b_vld), longint'(hv[slot]));
    if (hv[slot]) begin
      for (int k = 0; k < 4; k++) begin
        chk({hs[slot], " R3 R4 R6 R7 R8 lane re A"},
            longint'($signed(a_out_re[k*A_OW +: A_OW])), ea_re[slot][k]);
        chk({hs[slot], " R3 R4 R6 R7 R8 lane im A"},
            longint'($signed(a_out_im[k*A_OW +: A_OW])), ea_im[slot][k]);
        chk({hs[slot], " R3 R5 R6 R7 R8 lane re B"},
            longint'($signed(b_out_re[k*B_OW +: B_OW])), eb_re[slot][k]);
        chk({hs[slot], " R3 R5 R6 R7 R8 lane im B"},
            longint'($signed(b_out_im[k*B_OW +: B_OW])), eb_im[slot][k]);
      end
    end
  endtask

  initial begin
    for (int s = 0; s < 8; s++) begin hv[s] = 1'b0; hs[s] = ""; end
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset out_valid A", longint'(a_vld), 0);
    chk("R1 reset out_valid B", longint'(b_vld), 0);
    chk("R1 reset data A", longint'(a_out_re | a_out_im), 0);
    chk("R1 reset data B", longint'(b_out_re | b_out_im), 0);
    rst_n = 1'b1;
    for (int t = 0; t < NCYC; t++) begin
      @(negedge clk);
      check_out(t);
      if (t < 12)       drive(t, 1'b1, "directed");
      else if (t < 60)  drive(t, 1'b1, "R9 burst");
      else if (t < NCYC - 8) drive(t, ($urandom % 4) != 0, "random");
      else              drive(t, 1'b0, "drain");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule